// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator

This block generates several independent pulse-width modulated outputs, one pin per channel, each timed by a counter on the peripheral clock. Software sets each channel through a synchronous word-wide register port. Every channel has a window of 32 bytes holding a period count, a high-time (duty) count, a control word and one reserved slot. Period and duty writes go into staging registers. They reach the waveform only when software writes a one to the channel's run bit. On a channel that is already running, that snapshot is then applied at the next period boundary, so no period is cut short or stretched.

The control word holds a run bit, an output inversion bit and a hold bit. The hold bit decides what the pin does while the channel is stopped: it either freezes at its last level or returns to the idle level. A synchronous active-high reset stops every channel and clears all registers.

Top module: `multi_pwm`

## Requirements
- R1: After reset every register reads zero, every channel is stopped with no inversion, and every `pwm_out` bit is 0.
- R2: Within a channel window, offset 0x0 holds the period and offset 0x4 holds the duty, both full 32-bit cycle counts. Reading either returns the last value written, even when that value has not yet been applied.
- R3: Control offset 0xC: bit 0 is run, bit 1 is invert and bit 2 is hold. These three bits read back as written and bits 31..3 read as zero.
- R4: While running with applied period P and duty D, the output is active for the first min(D,P) of every P cycles. D=0 gives a constant inactive output, D>=P gives a constant active output, and P=0 holds the output inactive. The active level is 1 without inversion.
- R5: With invert set, the output is the complement of the R4 waveform.
- R6: Writing control with bit 0 set on a stopped channel applies the staged period and duty at once and starts a new period. On a running channel, period and duty writes leave the waveform unchanged until control is written with bit 0 set. The values staged at that write are then applied from the next period boundary.
- R7: While a channel is stopped with hold clear, its output sits at the idle level, which equals the invert bit. With hold set, the output keeps the level it had when the channel stopped.
- R8: Reads of offset 0x8, of any offset other than 0x0, 0x4 and 0xC, or of a window at or above channel NUM_CH return zero. Writes to those addresses change no register.
- R9: A read returns its data on `rdata` one clock after `rd_en` is sampled. `rdata` holds that value until the next read.
- R10: Channels run independently. A write to one channel's window does not change another channel's waveform or registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read request, data one cycle later |
| addr | input | ADDR_W | Byte address, bits [4:0] select the register, upper bits the channel |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwm_out | output | NUM_CH | One modulated output per channel |

## Verification
The bench covers the waveform edge cases: zero duty, duty equal to and larger than the period, a zero period, and a one-cycle period. A comparator that used the wrong bound or wrap point would show up as one extra or one missing high cycle per period. It checks that a duty rewrite on a running channel leaves the waveform alone until the run bit is written again. A design that applied staged values straight away would show the new count too early, and one that never applied them would keep the old count.

It also stops channels with hold set and with hold clear, and with inversion on and off. An idle-level mistake would leave the pin at the wrong level. Reads of the reserved slot, of undefined offsets and of windows above the last channel must return zero. A write that aliased onto a real channel would corrupt that channel's period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam logic [4:0] OFF_PERIOD = 5'h00;
  localparam logic [4:0] OFF_DUTY   = 5'h04;
  localparam logic [4:0] OFF_CTRL   = 5'h0C;

  localparam int BIT_RUN    = 0;
  localparam int BIT_INVERT = 1;
  localparam int BIT_HOLD   = 2;

  typedef struct packed {
    logic hold;
    logic invert;
    logic run;
  } chan_ctrl_t;
endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_period,
  input  logic              wr_duty,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] stage_period,
  output logic [DATA_W-1:0] stage_duty,
  output chan_ctrl_t        ctrl,
  output logic              arm
);
  assign arm = wr_ctrl & wdata[BIT_RUN];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_period <= '0;
      stage_duty   <= '0;
      ctrl         <= '0;
    end else begin
      if (wr_period) stage_period <= wdata;
      if (wr_duty)   stage_duty   <= wdata;
      if (wr_ctrl) begin
        ctrl.run    <= wdata[BIT_RUN];
        ctrl.invert <= wdata[BIT_INVERT];
        ctrl.hold   <= wdata[BIT_HOLD];
      end
    end
  end
endmodule

// File: rtl/pwm_chan_core.sv
module pwm_chan_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              invert,
  input  logic              hold,
  input  logic              arm,
  input  logic [DATA_W-1:0] stage_period,
  input  logic [DATA_W-1:0] stage_duty,
  output logic              pwm_o
);
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] act_period, act_duty;
  logic [DATA_W-1:0] pend_period, pend_duty;
  logic              pend_valid;
  logic              last_cycle;
  logic              active;

  assign last_cycle = (act_period == '0) || (cnt >= act_period - DATA_W'(1));
  assign active     = (act_period != '0) && (cnt < act_duty);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      act_period  <= '0;
      act_duty    <= '0;
      pend_period <= '0;
      pend_duty   <= '0;
      pend_valid  <= 1'b0;
    end else if (!run) begin
      cnt        <= '0;
      pend_valid <= 1'b0;
      if (arm) begin
        act_period <= stage_period;
        act_duty   <= stage_duty;
      end
    end else begin
      if (last_cycle) begin
        cnt <= '0;
        if (pend_valid) begin
          act_period <= pend_period;
          act_duty   <= pend_duty;
          pend_valid <= 1'b0;
        end
      end else begin
        cnt <= cnt + DATA_W'(1);
      end
      if (arm) begin
        pend_period <= stage_period;
        pend_duty   <= stage_duty;
        pend_valid  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        pwm_o <= 1'b0;
    else if (run)   pwm_o <= active ^ invert;
    else if (!hold) pwm_o <= invert;
  end
endmodule

// File: rtl/multi_pwm.sv
module multi_pwm
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int DATA_W = 32;
  localparam int CH_W   = ADDR_W - 5;

  logic [CH_W-1:0]   sel_ch;
  logic [4:0]        sel_off;
  logic              sel_hit;
  logic [DATA_W-1:0] per_q  [NUM_CH];
  logic [DATA_W-1:0] duty_q [NUM_CH];
  chan_ctrl_t        ctrl_q [NUM_CH];
  logic [NUM_CH-1:0] en_vec, pol_vec, keep_vec;
  logic [DATA_W-1:0] rd_val;

  assign sel_ch  = addr[ADDR_W-1:5];
  assign sel_off = addr[4:0];
  assign sel_hit = int'(sel_ch) < NUM_CH;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic arm_i;
    logic ch_sel;
    assign ch_sel = wr_en && sel_hit && (sel_ch == CH_W'(i));

    pwm_chan_regs #(.DATA_W(DATA_W)) u_regs (
      .clk          (clk),
      .rst          (rst),
      .wr_period    (ch_sel && sel_off == OFF_PERIOD),
      .wr_duty      (ch_sel && sel_off == OFF_DUTY),
      .wr_ctrl      (ch_sel && sel_off == OFF_CTRL),
      .wdata        (wdata),
      .stage_period (per_q[i]),
      .stage_duty   (duty_q[i]),
      .ctrl         (ctrl_q[i]),
      .arm          (arm_i)
    );

    pwm_chan_core #(.DATA_W(DATA_W)) u_core (
      .clk          (clk),
      .rst          (rst),
      .run          (ctrl_q[i].run),
      .invert       (ctrl_q[i].invert),
      .hold         (ctrl_q[i].hold),
      .arm          (arm_i),
      .stage_period (per_q[i]),
      .stage_duty   (duty_q[i]),
      .pwm_o        (pwm_out[i])
    );

    assign en_vec[i]   = ctrl_q[i].run;
    assign pol_vec[i]  = ctrl_q[i].invert;
    assign keep_vec[i] = ctrl_q[i].hold;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_hit && sel_ch == CH_W'(i)) begin
        case (sel_off)
          OFF_PERIOD: rd_val = per_q[i];
          OFF_DUTY:   rd_val = duty_q[i];
          OFF_CTRL:   rd_val = {29'b0, ctrl_q[i]};
          default:    rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

// File: rtl/multi_pwm_chk.sv
module multi_pwm_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic [NUM_CH-1:0] pwm_out,
  input logic [NUM_CH-1:0] en_vec,
  input logic [NUM_CH-1:0] pol_vec,
  input logic [NUM_CH-1:0] keep_vec
);
  assert_reset_out_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pwm_out == '0 && rdata == '0));

  assert_ctrl_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(addr[4:0]) == 5'h0C) |-> (rdata[31:3] == '0));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(addr[4:0]) == 5'h08) |-> (rdata == '0));

  assert_high_window_zero_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && (int'($past(addr[ADDR_W-1:5])) >= NUM_CH)) |-> (rdata == '0));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rd_en) && !$past(rst)) |-> $stable(rdata));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
      (!en_vec[i] && !keep_vec[i]) |=> (pwm_out[i] == $past(pol_vec[i])));

    assert_hold_level_R7: assert property (@(posedge clk) disable iff (rst)
      (!en_vec[i] && keep_vec[i]) |=> $stable(pwm_out[i]));
  end
endmodule

bind multi_pwm multi_pwm_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .addr     (addr),
  .rdata    (rdata),
  .pwm_out  (pwm_out),
  .en_vec   (en_vec),
  .pol_vec  (pol_vec),
  .keep_vec (keep_vec)
);

// File: tb/multi_pwm_test.sv
`timescale 1ns/1ps
module multi_pwm_test;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NUM_CH-1:0] pwm_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  int highs [NUM_CH];

  // period, duty, invert, expected active samples per window
  localparam int VEC [8][4] = '{
    '{10, 3, 0, 3},
    '{10, 0, 0, 0},
    '{10, 10, 0, 10},
    '{10, 15, 0, 10},
    '{0, 5, 0, 0},
    '{8, 2, 1, 6},
    '{1, 1, 0, 1},
    '{5, 4, 0, 4}
  };

  multi_pwm #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic measure(input int win);
    for (int c = 0; c < NUM_CH; c++) highs[c] = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      for (int c = 0; c < NUM_CH; c++) if (pwm_out[c]) highs[c]++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    check("R1 pwm_out", 32'(pwm_out), 32'h0);
    rd(32'h0C, d); check("R1 ctrl", d, 32'h0);
    rd(32'h00, d); check("R1 period", d, 32'h0);

    // R4 R5 R6: vector table on channel 0
    for (int v = 0; v < 8; v++) begin
      int win;
      win = (VEC[v][0] == 0) ? 8 : VEC[v][0];
      wr(32'h0C, 32'h0);
      wr(32'h00, 32'(VEC[v][0]));
      wr(32'h04, 32'(VEC[v][1]));
      wr(32'h0C, {30'b0, VEC[v][2] != 0, 1'b1});
      measure(win);
      check(VEC[v][2] != 0 ? "R5 inverted waveform" : "R4 waveform", 32'(highs[0]), 32'(VEC[v][3]));
    end

    // R2 R9: readback of staged values
    wr(32'h20, 32'hDEAD_BEEF);
    wr(32'h24, 32'h1234_5678);
    rd(32'h20, d); check("R2 period readback", d, 32'hDEAD_BEEF);
    rd(32'h24, d); check("R2 duty readback", d, 32'h1234_5678);
    repeat (3) @(negedge clk);
    check("R9 rdata held", rdata, 32'h1234_5678);

    // R3: control readback
    wr(32'h2C, 32'hFFFF_FFF6);
    rd(32'h2C, d); check("R3 ctrl masked", d, 32'h6);
    wr(32'h2C, 32'h0);

    // R6: refresh on running channel
    wr(32'h0C, 32'h0);
    wr(32'h00, 32'd10);
    wr(32'h04, 32'd3);
    wr(32'h0C, 32'h1);
    wr(32'h04, 32'd7);
    measure(10);
    check("R6 staged not applied", 32'(highs[0]), 32'd3);
    rd(32'h04, d); check("R2 staged duty readback", d, 32'd7);
    rd(32'h0C, d); check("R3 run bit readback", d, 32'h1);
    wr(32'h0C, 32'h1);
    repeat (25) @(negedge clk);
    measure(10);
    check("R6 applied after rearm", 32'(highs[0]), 32'd7);

    // R7: stop with hold and without
    wr(32'h0C, 32'h0);
    wr(32'h00, 32'd4);
    wr(32'h04, 32'd4);
    wr(32'h0C, 32'h5);
    repeat (3) @(negedge clk);
    wr(32'h0C, 32'h4);
    repeat (3) @(negedge clk);
    check("R7 hold keeps level", 32'(pwm_out[0]), 32'h1);
    wr(32'h0C, 32'h0);
    repeat (2) @(negedge clk);
    check("R7 idle level plain", 32'(pwm_out[0]), 32'h0);
    wr(32'h0C, 32'h2);
    repeat (2) @(negedge clk);
    check("R7 idle level inverted", 32'(pwm_out[0]), 32'h1);
    wr(32'h0C, 32'h0);

    // R8: undefined locations
    wr(32'h00, 32'd9);
    wr(32'h08, 32'hFFFF_FFFF);
    rd(32'h08, d); check("R8 reserved slot", d, 32'h0);
    rd(32'h10, d); check("R8 undefined offset", d, 32'h0);
    wr(32'h80, 32'h5555_5555);
    rd(32'h80, d); check("R8 high window", d, 32'h0);
    rd(32'h00, d); check("R8 no alias write", d, 32'd9);

    // R10: independent channels
    wr(32'h20, 32'd6);
    wr(32'h24, 32'd2);
    wr(32'h40, 32'd6);
    wr(32'h44, 32'd5);
    wr(32'h2C, 32'h1);
    wr(32'h4C, 32'h1);
    measure(12);
    check("R10 channel1", 32'(highs[1]), 32'd4);
    check("R10 channel2", 32'(highs[2]), 32'd10);
    check("R10 channel3 idle", 32'(highs[3]), 32'd0);
    wr(32'h44, 32'd1);
    wr(32'h4C, 32'h1);
    repeat (15) @(negedge clk);
    measure(12);
    check("R10 channel1 unaffected", 32'(highs[1]), 32'd4);
    check("R10 channel2 updated", 32'(highs[2]), 32'd2);

    // R1: reset clears running channels
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 reset outputs", 32'(pwm_out), 32'h0);
    rd(32'h2C, d); check("R1 reset ctrl", d, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule